// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block collects fifteen interrupt request sources, masks each with its own enable bit and a master enable, and places each at a high or a low priority level. Out of the requests still standing, it picks one winner and presents its vector index to the CPU together with a valid flag. The CPU takes the interrupt with an acknowledge strobe and signals the end of a service routine with a return strobe.

Two of the sources are active-low external pins. Each pin can be set to follow its synchronized level or to latch falling edges. Four capture pins act as further external requests, each of which can be made sensitive to rising edges, falling edges, both or neither. The other nine sources are level requests from on-chip peripherals. The controller keeps one in-service bit per level, so a high-level request can interrupt a running low-level routine but nothing interrupts a high-level one. While a DMA transfer is running, no interrupt is offered or accepted.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, all enables, priority bits, trigger settings and in-service bits are zero and `irq_valid` is low.
- R2: A source can win only when its own enable bit is set and the master enable is set. A write with `cfg_sel`=0 loads the source enables from `cfg_wdata[14:0]` and the master enable from bit 15.
- R3: The source index is the vector index (0..14). Source 0 is ext pin 0, 1 is `periph_req[0]`, 2 is ext pin 1, 3 is `periph_req[1]`, 4..7 are capture pins 0..3, and 8..14 are `periph_req[2..8]`. Within one level the lowest pending index wins.
- R4: When requests at both levels are pending, a high-level request wins. A write with `cfg_sel`=1 loads the priority bits from `cfg_wdata[14:0]`, where 1 means high.
- R5: An accepted acknowledge (`ack` while `irq_valid`) sets the in-service bit of the winner's level. While the low level is in service only high-level requests are offered. While the high level is in service nothing is offered.
- R6: `reti` clears the high in-service bit if it is set, and otherwise clears the low one.
- R7: An ext pin in level mode (trigger bit 0) requests while its synchronized input is low. Nothing is latched.
- R8: An ext pin in edge mode (trigger bit 1) latches a falling edge. The latched request stays until that source is acknowledged.
- R9: A capture pin latches a rising edge when its rise bit is set and a falling edge when its fall bit is set. The latched request is cleared when that source is acknowledged.
- R10: While `dma_busy` is high, `irq_valid` is low and `ack` has no effect.
- R11: A write with `cfg_sel`=2 loads the trigger word: bits 1:0 are the ext0/ext1 edge modes, bits 5:2 the capture rise enables, and bits 9:6 the capture fall enables. A write with `cfg_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | External interrupt pins, active low |
| cap_pin | input | 4 | Capture event pins |
| periph_req | input | 9 | Level requests from on-chip peripherals |
| dma_busy | input | 1 | DMA transfer running; blocks interrupts |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| ack | input | 1 | CPU acknowledge of the presented interrupt |
| reti | input | 1 | Return from interrupt service |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vec | output | 4 | Vector index of the offered interrupt |

## Verification
The hardest state to reach is a doubly nested one. A low-level routine must be in service and then be interrupted by a high-level one, and the stimulus has to show that the two returns unwind it in the right order. The bench gets there in steps. It acknowledges a low-level peripheral request, then raises a high-priority request and acknowledges that as well. It then shows that the still-asserted high request comes back after the first return, and that the low one reappears only after the second return. Edge-latched capture and pin requests are checked after one acknowledge and one return, which proves that acknowledge cleared the latch.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_n,
  input  logic [3:0]  cap_pin,
  input  logic [8:0]  periph_req,
  input  logic        dma_busy,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        ack,
  input  logic        reti,
  output logic        irq_valid,
  output logic [3:0]  irq_vec
);
  localparam int NSRC = 15;

  logic [15:0]     ien;
  logic [NSRC-1:0] pri;
  logic [9:0]      trig;
  logic [1:0]      ex_s1, ex_s2, ex_s3, ex_flag;
  logic [3:0]      cp_s1, cp_s2, cp_s3, cp_flag;
  logic [1:0]      insvc;
  logic [NSRC-1:0] req, qual, hi, lo;
  logic            take_hi, take_lo, grant;

  function automatic logic [3:0] first_set(input logic [NSRC-1:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = 4'(i);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien  <= '0;
      pri  <= '0;
      trig <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: ien  <= cfg_wdata;
        2'd1: pri  <= cfg_wdata[NSRC-1:0];
        2'd2: trig <= cfg_wdata[9:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ex_s1 <= '1; ex_s2 <= '1; ex_s3 <= '1;
      cp_s1 <= '0; cp_s2 <= '0; cp_s3 <= '0;
    end else begin
      ex_s1 <= ext_n;   ex_s2 <= ex_s1; ex_s3 <= ex_s2;
      cp_s1 <= cap_pin; cp_s2 <= cp_s1; cp_s3 <= cp_s2;
    end

  wire [1:0] ex_fall = ex_s3 & ~ex_s2 & trig[1:0];
  wire [3:0] cp_edge = (cp_s2 & ~cp_s3 & trig[5:2]) | (~cp_s2 & cp_s3 & trig[9:6]);

  assign req[0]    = trig[0] ? ex_flag[0] : ~ex_s2[0];
  assign req[1]    = periph_req[0];
  assign req[2]    = trig[1] ? ex_flag[1] : ~ex_s2[1];
  assign req[3]    = periph_req[1];
  assign req[7:4]  = cp_flag;
  assign req[14:8] = periph_req[8:2];

  assign qual    = req & ien[NSRC-1:0] & {NSRC{ien[15]}};
  assign hi      = qual & pri;
  assign lo      = qual & ~pri;
  assign take_hi = !insvc[1] && (|hi);
  assign take_lo = (insvc == 2'b00) && (|lo);

  assign irq_valid = !dma_busy && (take_hi || take_lo);
  assign irq_vec   = first_set(take_hi ? hi : lo);
  assign grant     = irq_valid && ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ex_flag <= '0;
      cp_flag <= '0;
    end else begin
      for (int k = 0; k < 2; k++)
        if (ex_fall[k]) ex_flag[k] <= 1'b1;
        else if (grant && irq_vec == 4'(2 * k)) ex_flag[k] <= 1'b0;
      for (int k = 0; k < 4; k++)
        if (cp_edge[k]) cp_flag[k] <= 1'b1;
        else if (grant && irq_vec == 4'(4 + k)) cp_flag[k] <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) insvc <= '0;
    else begin
      logic [1:0] nxt;
      nxt = insvc;
      if (reti) begin
        if (nxt[1]) nxt[1] = 1'b0;
        else        nxt[0] = 1'b0;
      end
      if (grant) nxt[take_hi ? 1 : 0] = 1'b1;
      insvc <= nxt;
    end
endmodule

module irq_nest_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dma_busy,
  input logic       ack,
  input logic       reti,
  input logic       irq_valid,
  input logic [3:0] irq_vec,
  input logic [1:0] insvc
);
  // R10
  dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |-> !irq_valid);
  // R10
  dma_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && !reti) |=> insvc == $past(insvc));
  // R5
  high_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insvc[1] |-> !irq_valid);
  // R5
  ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ack && !reti) |=> insvc != 2'b00);
  // R3
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vec < 4'd15);
  // R6
  reti_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && insvc[1]) |=> (!insvc[1] && insvc[0] == $past(insvc[0])));
  // R6
  reti_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && insvc == 2'b01) |=> insvc == 2'b00);
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_busy(dma_busy), .ack(ack), .reti(reti),
  .irq_valid(irq_valid), .irq_vec(irq_vec), .insvc(insvc)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  logic clk = 0, rst_n = 0;
  logic [1:0] ext_n = '1;
  logic [3:0] cap_pin = '0;
  logic [8:0] periph_req = '0;
  logic dma_busy = 0, cfg_we = 0, ack = 0, reti = 0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic irq_valid;
  logic [3:0] irq_vec;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_nest_ctrl dut (.*);

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d; tick(1); cfg_we = 0;
  endtask

  task automatic do_ack();  ack = 1;  tick(1); ack = 0;  tick(1); endtask
  task automatic do_reti(); reti = 1; tick(1); reti = 0; tick(1); endtask

  function automatic bit is_lvl(int i);
    return !(i >= 4 && i <= 7);
  endfunction

  task automatic set_src(int i, bit v);
    case (i)
      0: ext_n[0] = ~v;
      1: periph_req[0] = v;
      2: ext_n[1] = ~v;
      3: periph_req[1] = v;
      default: periph_req[i-6] = v;
    endcase
  endtask

  task automatic chk(string r, bit v_exp, int vec_exp);
    checks++;
    if (irq_valid !== v_exp || (v_exp && irq_vec !== 4'(vec_exp))) begin
      errors++;
      $display("FAIL %s: valid=%0b vec=%0d expected valid=%0b vec=%0d",
               r, irq_valid, irq_vec, v_exp, vec_exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    chk("R1 reset idle", 0, 0);
    ext_n = 2'b00; periph_req = '1; tick(4);
    chk("R1 all disabled after reset", 0, 0);
    ext_n = '1; periph_req = '0; tick(4);

    // R2: own enable alone is not enough; master enable required
    for (int i = 0; i < 15; i++) if (is_lvl(i)) begin
      set_src(i, 1);
      wr(0, 16'(1 << i)); tick(3);
      chk("R2 no master enable", 0, 0);
      wr(0, 16'(1 << i) | 16'h8000); tick(1);
      chk("R2 enabled source", 1, i);
      wr(0, 16'h7fff & ~16'(1 << i) | 16'h8000); tick(1);
      chk("R2 own enable cleared", 0, 0);
      set_src(i, 0); tick(3);
    end

    // R3: lowest index wins; drop winners in turn
    wr(0, 16'hffff);
    for (int i = 0; i < 15; i++) if (is_lvl(i)) set_src(i, 1);
    tick(4);
    for (int i = 0; i < 15; i++) if (is_lvl(i)) begin
      chk("R3 lowest index wins", 1, i);
      set_src(i, 0); tick(4);
    end
    chk("R3 none pending", 0, 0);

    // R4: single high-priority source beats all low ones
    for (int i = 0; i < 15; i++) if (is_lvl(i)) set_src(i, 1);
    tick(4);
    for (int j = 0; j < 15; j++) if (is_lvl(j)) begin
      wr(1, 16'(1 << j)); tick(1);
      chk("R4 high level wins", 1, j);
    end
    wr(1, 16'h0);
    for (int i = 0; i < 15; i++) if (is_lvl(i)) set_src(i, 0);
    tick(4);

    // R5 / R6: nesting and unwinding
    wr(1, 16'(1 << 12));
    set_src(14, 1); tick(1);
    chk("R5 low request offered", 1, 14);
    do_ack();
    chk("R5 low blocks low", 0, 0);
    set_src(13, 1); tick(1);
    chk("R5 second low blocked", 0, 0);
    set_src(12, 1); tick(1);
    chk("R5 high preempts low", 1, 12);
    do_ack();
    chk("R5 high in service blocks all", 0, 0);
    do_reti();
    chk("R6 first return pops high", 1, 12);
    set_src(12, 0); tick(1);
    chk("R6 low still in service", 0, 0);
    do_reti();
    chk("R6 second return pops low", 1, 13);
    set_src(13, 0); set_src(14, 0); wr(1, 16'h0); tick(1);
    chk("R6 idle after unwinding", 0, 0);

    // R7: level mode follows the pin
    ext_n[0] = 0; tick(4);
    chk("R7 level pin low", 1, 0);
    ext_n[0] = 1; tick(4);
    chk("R7 level not latched", 0, 0);

    // R8: ext1 edge mode latches
    wr(2, 16'h0002);
    ext_n[1] = 0; tick(1); ext_n[1] = 1; tick(5);
    chk("R8 falling edge latched", 1, 2);
    do_ack(); do_reti();
    chk("R8 latch cleared by ack", 0, 0);
    ext_n[1] = 0; tick(5);
    chk("R8 held low after edge", 1, 2);
    do_ack(); do_reti();
    chk("R8 no re-trigger while low", 0, 0);
    ext_n[1] = 1; tick(4);

    // R9 / R11: capture edges, rise={0,2}, fall={1,2}
    begin
      logic [3:0] rise_en = 4'b0101, fall_en = 4'b0110;
      wr(2, {6'd0, fall_en, rise_en, 2'b00});
      for (int k = 0; k < 4; k++) begin
        cap_pin[k] = 1; tick(5);
        chk("R9 capture rising", rise_en[k], 4 + k);
        if (rise_en[k]) begin
          do_ack(); do_reti();
          chk("R9 capture cleared by ack", 0, 0);
        end
        cap_pin[k] = 0; tick(5);
        chk("R9 capture falling", fall_en[k], 4 + k);
        if (fall_en[k]) begin
          do_ack(); do_reti();
          chk("R9 capture cleared by ack", 0, 0);
        end
      end
    end
    wr(2, 16'h0);

    // R10: DMA blocks offering and acceptance
    set_src(12, 1); tick(1);
    chk("R10 request before dma", 1, 12);
    dma_busy = 1; tick(1);
    chk("R10 blocked during dma", 0, 0);
    do_ack();
    dma_busy = 0; tick(1);
    chk("R10 ack ignored during dma", 1, 12);

    // R11: select 3 writes nothing
    wr(3, 16'h0); tick(1);
    chk("R11 select 3 ignored", 1, 12);
    wr(0, 16'h7fff); tick(1);
    chk("R11 master enable cleared", 0, 0);
    set_src(12, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule